// File: doc/BRIEF.md
# Interrupt Priority Level Evaluator

This block decides whether a pending interrupt outranks the level the processor is currently running at. It holds two small registers, written by the surrounding control logic: a software interrupt request register and a current priority level register. It also samples a vector of external interrupt lines. When the evaluate strobe rises, it works out one pending priority level from the pending requests and compares it with the current level.

A software request bit at position i stands for level i − 3, so bits 4 to 18 cover levels 1 to 15. An external line sits at a bit position above the software field, and its level is that bit position. When any external line is pending, the highest pending external line sets the level and the software requests are not used for the level. When the evaluation wins, the block gives a one-cycle take pulse and latches two values: a summary word, which holds every pending request at its own bit position, and the winning level.

Top module: `irq_level_eval`

## Requirements
- R1: After reset the take output is 0, the summary, the latched level, the software request readback and the priority level readback all read 0.
- R2: A write to the software request register keeps only bits 4 to 18 of the written word (mask 0x7FFF0). Every other bit of the readback is 0.
- R3: A write to the current priority level register keeps only the low 5 bits of the written word.
- R4: With no external line pending, the evaluated level is (i − 4) + 1, where i is the highest set bit of the software request register. The levels run from 1 (bit 4) to 15 (bit 18).
- R5: External line j is summary bit EXT_LO + j and stands for level EXT_LO + j (20 to 23 by default). When any external line is pending, the highest pending line gives the level, even if the software requests are higher in bit terms.
- R6: On a taken interrupt the summary output becomes the OR of all pending software bits and all pending external lines, each at its own bit position. The latched level output becomes the evaluated level.
- R7: An interrupt is taken only when the evaluated level is nonzero and strictly greater than the current priority level. When the evaluation does not win, the take output stays 0 and the summary and level outputs keep their values.
- R8: The take output goes to 1 for exactly one cycle. It does so in the cycle after the clock edge at which the evaluate strobe is first seen high. Holding the strobe high for several cycles gives only one evaluation.
- R9: When a register write and an evaluation fall on the same clock edge, the evaluation uses the register contents from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_wr_en | input | 1 | Write strobe for the software request register |
| sw_wr_data | input | DATA_W | Data for the software request register |
| ipl_wr_en | input | 1 | Write strobe for the current priority level register |
| ipl_wr_data | input | DATA_W | Data for the current priority level register |
| ext_irq | input | EXT_W | External interrupt lines, level sensitive |
| eval | input | 1 | Evaluate strobe; its rising edge is the trigger |
| take_irq | output | 1 | One-cycle pulse when an interrupt is taken |
| irq_summary | output | EXT_LO+EXT_W | Latched summary of pending requests |
| irq_level | output | 5 | Latched winning level |
| sw_req_rd | output | DATA_W | Readback of the software request register |
| ipl_rd | output | 5 | Readback of the current priority level |

## Verification
A register write and an evaluation can fall on the same clock edge. In that case the comparison must use the values held before the edge. The bench provokes this by raising the evaluate strobe in the same cycle as it writes a blocking priority level and clears the software requests. It expects a take based on the old contents. A follow-up evaluation must then see the new contents and not take. A second overlap is the strobe staying high over several edges. The bench judges it by expecting one take followed by cycles with no take and unchanged latched values.

// File: rtl/irq_eval_pkg.sv
package irq_eval_pkg;
  localparam int SW_LO = 4;
  localparam int SW_HI = 18;
  localparam int SW_N  = SW_HI - SW_LO + 1;
  localparam int LVL_W = 5;

  typedef struct packed {
    logic             hit;
    logic [LVL_W-1:0] lvl;
  } lvl_pick_t;

  // level carried by a software request bit at absolute position pos
  function automatic logic [LVL_W-1:0] sw_bit_to_level(input int pos);
    return LVL_W'(pos - SW_LO + 1);
  endfunction

  // level carried by an external line at absolute position pos
  function automatic logic [LVL_W-1:0] ext_bit_to_level(input int pos);
    return LVL_W'(pos);
  endfunction

  // strictly-higher, nonzero comparison
  function automatic logic level_wins(input logic [LVL_W-1:0] lvl,
                                      input logic [LVL_W-1:0] cur);
    return (lvl != '0) && (lvl > cur);
  endfunction
endpackage

// File: rtl/irq_eval_regs.sv
module irq_eval_regs
  import irq_eval_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sw_wr_en,
  input  logic [DATA_W-1:0]    sw_wr_data,
  input  logic                 ipl_wr_en,
  input  logic [DATA_W-1:0]    ipl_wr_data,
  output logic [SW_N-1:0]      sw_bits,
  output logic [LVL_W-1:0]     cur_ipl
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sw_bits <= '0;
      cur_ipl <= '0;
    end else begin
      if (sw_wr_en)  sw_bits <= sw_wr_data[SW_HI:SW_LO];
      if (ipl_wr_en) cur_ipl <= ipl_wr_data[LVL_W-1:0];
    end
  end
endmodule

// File: rtl/irq_sw_scan.sv
module irq_sw_scan
  import irq_eval_pkg::*;
(
  input  logic [SW_N-1:0] pend,
  output lvl_pick_t       pick
);
  logic [LVL_W-1:0] cand [SW_N];

  for (genvar g = 0; g < SW_N; g++) begin : g_cand
    assign cand[g] = sw_bit_to_level(SW_LO + g);
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < SW_N; i++) begin
      if (pend[i]) begin
        pick.hit = 1'b1;
        pick.lvl = cand[i];
      end
    end
  end
endmodule

// File: rtl/irq_ext_scan.sv
module irq_ext_scan
  import irq_eval_pkg::*;
#(
  parameter int EXT_LO = 20,
  parameter int EXT_W  = 4
) (
  input  logic [EXT_W-1:0] lines,
  output lvl_pick_t        pick
);
  logic [LVL_W-1:0] cand [EXT_W];

  for (genvar g = 0; g < EXT_W; g++) begin : g_cand
    assign cand[g] = ext_bit_to_level(EXT_LO + g);
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < EXT_W; i++) begin
      if (lines[i]) begin
        pick.hit = 1'b1;
        pick.lvl = cand[i];
      end
    end
  end
endmodule

// File: rtl/irq_eval_decide.sv
module irq_eval_decide
  import irq_eval_pkg::*;
#(
  parameter int EXT_LO = 20,
  parameter int EXT_W  = 4,
  localparam int SUM_W = EXT_LO + EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval,
  input  lvl_pick_t        sw_pick,
  input  lvl_pick_t        ext_pick,
  input  logic [SW_N-1:0]  sw_bits,
  input  logic [EXT_W-1:0] ext_lines,
  input  logic [LVL_W-1:0] cur_ipl,
  output logic             eval_edge,
  output logic             win,
  output logic [LVL_W-1:0] lvl_next,
  output logic             take,
  output logic [SUM_W-1:0] summary,
  output logic [LVL_W-1:0] level_id
);
  logic             eval_d;
  logic [SUM_W-1:0] sum_next;

  assign eval_edge = eval & ~eval_d;

  always_comb begin
    lvl_next = '0;
    if (ext_pick.hit)     lvl_next = ext_pick.lvl;
    else if (sw_pick.hit) lvl_next = sw_pick.lvl;
  end

  assign win = level_wins(lvl_next, cur_ipl);

  always_comb begin
    sum_next = '0;
    sum_next[SW_HI:SW_LO]     = sw_bits;
    sum_next[EXT_LO +: EXT_W] = ext_lines;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eval_d   <= 1'b0;
      take     <= 1'b0;
      summary  <= '0;
      level_id <= '0;
    end else begin
      eval_d <= eval;
      take   <= eval_edge & win;
      if (eval_edge & win) begin
        summary  <= sum_next;
        level_id <= lvl_next;
      end
    end
  end
endmodule

// File: rtl/irq_level_eval.sv
module irq_level_eval
  import irq_eval_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXT_LO = 20,
  parameter int EXT_W  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     sw_wr_en,
  input  logic [DATA_W-1:0]        sw_wr_data,
  input  logic                     ipl_wr_en,
  input  logic [DATA_W-1:0]        ipl_wr_data,
  input  logic [EXT_W-1:0]         ext_irq,
  input  logic                     eval,
  output logic                     take_irq,
  output logic [EXT_LO+EXT_W-1:0]  irq_summary,
  output logic [LVL_W-1:0]         irq_level,
  output logic [DATA_W-1:0]        sw_req_rd,
  output logic [LVL_W-1:0]         ipl_rd
);
  logic [SW_N-1:0]  sw_bits;
  logic [LVL_W-1:0] cur_ipl;
  lvl_pick_t        sw_pick;
  lvl_pick_t        ext_pick;
  logic             eval_edge;
  logic             win;
  logic [LVL_W-1:0] lvl_next;

  irq_eval_regs #(.DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .ipl_wr_en  (ipl_wr_en),
    .ipl_wr_data(ipl_wr_data),
    .sw_bits    (sw_bits),
    .cur_ipl    (cur_ipl)
  );

  irq_sw_scan u_sw_scan (
    .pend(sw_bits),
    .pick(sw_pick)
  );

  irq_ext_scan #(.EXT_LO(EXT_LO), .EXT_W(EXT_W)) u_ext_scan (
    .lines(ext_irq),
    .pick (ext_pick)
  );

  irq_eval_decide #(.EXT_LO(EXT_LO), .EXT_W(EXT_W)) u_decide (
    .clk      (clk),
    .rst_n    (rst_n),
    .eval     (eval),
    .sw_pick  (sw_pick),
    .ext_pick (ext_pick),
    .sw_bits  (sw_bits),
    .ext_lines(ext_irq),
    .cur_ipl  (cur_ipl),
    .eval_edge(eval_edge),
    .win      (win),
    .lvl_next (lvl_next),
    .take     (take_irq),
    .summary  (irq_summary),
    .level_id (irq_level)
  );

  always_comb begin
    sw_req_rd = '0;
    sw_req_rd[SW_HI:SW_LO] = sw_bits;
  end

  assign ipl_rd = cur_ipl;
endmodule

// File: rtl/irq_eval_checker.sv
module irq_eval_checker
  import irq_eval_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int EXT_LO = 20,
  parameter int EXT_W  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sw_wr_en,
  input logic [DATA_W-1:0]       sw_wr_data,
  input logic                    ipl_wr_en,
  input logic [DATA_W-1:0]       ipl_wr_data,
  input logic [EXT_W-1:0]        ext_irq,
  input logic                    eval,
  input logic                    take_irq,
  input logic [EXT_LO+EXT_W-1:0] irq_summary,
  input logic [LVL_W-1:0]        irq_level,
  input logic [DATA_W-1:0]       sw_req_rd,
  input logic [LVL_W-1:0]        ipl_rd,
  input logic                    eval_edge
);
  localparam logic [DATA_W-1:0] SW_MASK = DATA_W'(((1 << SW_N) - 1) << SW_LO);

  assert_sw_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sw_wr_en) |-> (sw_req_rd == ($past(sw_wr_data) & SW_MASK)));

  assert_ipl_low5_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ipl_wr_en) |-> (ipl_rd == $past(ipl_wr_data[LVL_W-1:0])));

  assert_sw_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && ($past(ext_irq) == '0)) |-> (irq_level <= LVL_W'(SW_N)));

  assert_ext_over_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && ($past(ext_irq) != '0)) |-> (irq_level >= LVL_W'(EXT_LO)));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take_irq |-> ($stable(irq_summary) && $stable(irq_level)));

  assert_above_ipl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> ((irq_level != '0) && (irq_level > $past(ipl_rd))));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq);

  assert_from_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(eval_edge));
endmodule

bind irq_level_eval irq_eval_checker #(
  .DATA_W(DATA_W), .EXT_LO(EXT_LO), .EXT_W(EXT_W)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .sw_wr_en   (sw_wr_en),
  .sw_wr_data (sw_wr_data),
  .ipl_wr_en  (ipl_wr_en),
  .ipl_wr_data(ipl_wr_data),
  .ext_irq    (ext_irq),
  .eval       (eval),
  .take_irq   (take_irq),
  .irq_summary(irq_summary),
  .irq_level  (irq_level),
  .sw_req_rd  (sw_req_rd),
  .ipl_rd     (ipl_rd),
  .eval_edge  (eval_edge)
);

// File: tb/test_irq_level_eval.sv
`timescale 1ns/1ps
module test_irq_level_eval;
  localparam int DW = 32;
  localparam int XL = 20;
  localparam int XW = 4;
  localparam int SW = XL + XW;

  typedef struct {
    logic          t;
    logic [SW-1:0] s;
    logic [4:0]    l;
    string         rq;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sw_wr_en = 1'b0;
  logic [DW-1:0] sw_wr_data = '0;
  logic          ipl_wr_en = 1'b0;
  logic [DW-1:0] ipl_wr_data = '0;
  logic [XW-1:0] ext_irq = '0;
  logic          eval = 1'b0;
  logic          take_irq;
  logic [SW-1:0] irq_summary;
  logic [4:0]    irq_level;
  logic [DW-1:0] sw_req_rd;
  logic [4:0]    ipl_rd;

  int checks = 0;
  int errors = 0;
  exp_t exp_q[$];

  logic [DW-1:0] sh_sw  = '0;
  logic [4:0]    sh_ipl = '0;
  logic [SW-1:0] held_s = '0;
  logic [4:0]    held_l = '0;

  always #2.5 clk = ~clk;

  irq_level_eval #(.DATA_W(DW), .EXT_LO(XL), .EXT_W(XW)) i_irq_level_eval (
    .clk(clk), .rst_n(rst_n),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
    .ipl_wr_en(ipl_wr_en), .ipl_wr_data(ipl_wr_data),
    .ext_irq(ext_irq), .eval(eval),
    .take_irq(take_irq), .irq_summary(irq_summary), .irq_level(irq_level),
    .sw_req_rd(sw_req_rd), .ipl_rd(ipl_rd)
  );

  task automatic check(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, expv);
    end
  endtask

  // Independent model: walk bits from the top down, external first.
  function automatic exp_t model(input logic [XW-1:0] ext, input string rq);
    exp_t e;
    logic [4:0] lvl = 5'd0;
    logic found = 1'b0;
    for (int k = XW - 1; k >= 0; k--)
      if (!found && ext[k]) begin lvl = 5'(XL + k); found = 1'b1; end
    for (int b = 18; b >= 4; b--)
      if (!found && sh_sw[b]) begin lvl = 5'(b - 3); found = 1'b1; end
    e.t = (lvl != 0) && (lvl > sh_ipl);
    if (e.t) begin
      held_s = sh_sw[SW-1:0] | (SW'(ext) << XL);
      held_l = lvl;
    end
    e.s = held_s;
    e.l = held_l;
    e.rq = rq;
    return e;
  endfunction

  task automatic wr_sw(input logic [DW-1:0] d);
    @(negedge clk); sw_wr_en = 1'b1; sw_wr_data = d;
    @(negedge clk); sw_wr_en = 1'b0;
    sh_sw = d & 32'h0007_FFF0;
  endtask

  task automatic wr_ipl(input logic [DW-1:0] d);
    @(negedge clk); ipl_wr_en = 1'b1; ipl_wr_data = d;
    @(negedge clk); ipl_wr_en = 1'b0;
    sh_ipl = d[4:0];
  endtask

  // evaluate with the strobe held for n edges
  task automatic run_eval(input logic [XW-1:0] ext, input int n, input string rq);
    exp_t e;
    @(negedge clk);
    ext_irq = ext;
    eval = 1'b1;
    e = model(ext, rq);
    exp_q.push_back(e);
    for (int i = 1; i < n; i++) begin
      e.t = 1'b0;
      exp_q.push_back(e);
    end
    for (int i = 0; i < n; i++) @(negedge clk);
    eval = 1'b0;
    @(negedge clk);
  endtask

  // monitor: outputs settle just after the edge that sampled the strobe
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        check(e.rq, "take",    32'(take_irq),    32'(e.t));
        check(e.rq, "summary", 32'(irq_summary), 32'(e.s));
        check(e.rq, "level",   32'(irq_level),   32'(e.l));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    exp_t e;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "take",    32'(take_irq), 0);
    check("R1", "summary", 32'(irq_summary), 0);
    check("R1", "level",   32'(irq_level), 0);
    check("R1", "swrd",    sw_req_rd, 0);
    check("R1", "iplrd",   32'(ipl_rd), 0);

    // R2 and R3 write masking
    wr_sw(32'hFFFF_FFFF);
    check("R2", "swrd", sw_req_rd, 32'h0007_FFF0);
    wr_sw(32'h0000_000F);
    check("R2", "swrd low", sw_req_rd, 32'h0);
    wr_ipl(32'hFFFF_FFE7);
    check("R3", "iplrd", 32'(ipl_rd), 32'd7);

    // R4 software level, R6 summary, R7 compare
    wr_ipl(32'd0);
    wr_sw(32'h0000_0210);                 // bits 4 and 9 -> level 6
    run_eval(4'b0000, 1, "R4");
    wr_ipl(32'd6);
    run_eval(4'b0000, 1, "R7");           // equal level: no take
    wr_ipl(32'd5);
    run_eval(4'b0000, 1, "R6");
    wr_sw(32'h0004_0000);                 // bit 18 -> level 15
    wr_ipl(32'd14);
    run_eval(4'b0000, 1, "R4");
    wr_ipl(32'd15);
    run_eval(4'b0000, 1, "R7");

    // R5 external precedence
    wr_sw(32'h0004_0210);
    wr_ipl(32'd5);
    run_eval(4'b0101, 1, "R5");           // levels 20,22 -> 22
    wr_ipl(32'd22);
    run_eval(4'b0101, 1, "R5");           // equal: no take
    wr_ipl(32'd21);
    run_eval(4'b1111, 1, "R5");           // level 23
    wr_ipl(32'd31);
    run_eval(4'b1000, 1, "R7");

    // R7 nothing pending never takes
    wr_sw(32'd0);
    wr_ipl(32'd0);
    run_eval(4'b0000, 1, "R7");

    // R8 held strobe: a single pulse
    wr_sw(32'h0000_0100);                 // bit 8 -> level 5
    run_eval(4'b0000, 3, "R8");

    // R9 writes on the same edge as the strobe
    wr_sw(32'h0000_0200);                 // level 6, ipl 0
    @(negedge clk);
    sw_wr_en = 1'b1;  sw_wr_data = 32'd0;
    ipl_wr_en = 1'b1; ipl_wr_data = 32'd31;
    ext_irq = '0;
    eval = 1'b1;
    e = model(4'b0000, "R9");             // old contents
    exp_q.push_back(e);
    @(negedge clk);
    sw_wr_en = 1'b0; ipl_wr_en = 1'b0; eval = 1'b0;
    sh_sw = '0; sh_ipl = 5'd31;
    check("R9", "iplrd", 32'(ipl_rd), 32'd31);
    @(negedge clk);
    run_eval(4'b0000, 1, "R9");           // new contents: no take

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule